// File: doc/BRIEF.md
# Dual Accumulator with Output Combiner

This block sits behind the multiplier array of a two-cell FIR engine. Each cell delivers four registered products every clock. The block adds each cell's four products together and accumulates that sum across cycles. Both cells share one accumulate-enable input.

Driving the enable low does two things at the same clock edge. It restarts each running sum from the current products only. It also copies the finished accumulator value into that cell's output holding register. The two holding registers then feed a combiner, which drives a registered 28-bit result. Software-free mode pins choose what that result is:

- the two cells added together,
- the two cells added with cell B first divided by 2^10, which joins both cells into one filter of extended precision,
- cell A alone,
- cell B alone.

Top module: `dual_accum_combiner`

## Requirements
- R1: A synchronous reset clears both accumulators, both holding registers and the output to zero.
- R2: On a clock edge where accEn is low, each cell's accumulator loads the sum of that cell's four current products only. No earlier accumulator value is added.
- R3: On a clock edge where accEn is low, each cell's holding register loads the value its accumulator held just before that edge.
- R4: On a clock edge where accEn is high, each accumulator adds the current four-product sum to its previous value, and both holding registers keep their values.
- R5: With modeSel = 2'b00, the output is holdA plus (holdB arithmetically shifted right by 10 bits). The shift truncates toward negative infinity, so a holdB of -1 contributes -1.
- R6: With modeSel = 2'b01, the output is holdA plus holdB.
- R7: With modeSel = 2'b10, the output is holdA. With modeSel = 2'b11, the output is holdB.
- R8: dataOut is registered. It reflects the holding registers and modeSel one clock after they are presented.
- R9: Products are 20-bit two's complement values, sign-extended to 28 bits. Product i of a cell sits at bits [20*i+19:20*i] of its bus. All 28-bit sums wrap modulo 2^28 without saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| accEn | input | 1 | High: accumulate. Low: restart the sums and load the holding registers |
| prodA | input | 80 | Four packed 20-bit signed products of cell A |
| prodB | input | 80 | Four packed 20-bit signed products of cell B |
| modeSel | input | 2 | Output combine mode (see R5 to R7) |
| dataOut | output | 28 | Registered combined result |

## Verification
The assertions check the following on every clock:

- the reload-versus-accumulate choice of each accumulator, computed from the product buses;
- the hold-load and hold-keep behaviour tied to accEn;
- the reset clearing;
- that dataOut equals the mode-selected combination of the previous cycle's holding registers.

Some behaviour only the bench scenarios can show. These are the sign-correct floor of the scaled mode on small negative values, wraparound after long accumulation runs of full-scale products, and the output staying frozen through a long enabled run. Another is the end-to-end agreement of accumulation lengths and mode switches with an independent arithmetic model.

// File: rtl/dac_pkg.sv
package dac_pkg;

  typedef struct packed {
    logic clearFb;
    logic loadHold;
  } dacStrobe_t;

  typedef enum logic [1:0] {
    MODE_SCALED = 2'b00,
    MODE_SUM    = 2'b01,
    MODE_A      = 2'b10,
    MODE_B      = 2'b11
  } combMode_e;

endpackage

// File: rtl/dac_ctrl.sv
module dac_ctrl
  import dac_pkg::*;
(
  input  logic       accEn,
  output dacStrobe_t strobe
);
  // A low enable both drops the feedback and captures the finished sum.
  always_comb begin
    strobe.clearFb  = !accEn;
    strobe.loadHold = !accEn;
  end
endmodule

// File: rtl/dac_datapath.sv
module dac_datapath
  import dac_pkg::*;
#(
  parameter int PROD_W   = 20,
  parameter int NUM_MULT = 4,
  parameter int ACC_W    = 28,
  parameter int NUM_CELL = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  dacStrobe_t                   strobe,
  input  logic [NUM_MULT*PROD_W-1:0]   prodBus [NUM_CELL],
  output logic signed [ACC_W-1:0]      accOut  [NUM_CELL],
  output logic signed [ACC_W-1:0]      holdOut [NUM_CELL]
);
  localparam int EXT_W = ACC_W - PROD_W;

  for (genvar c = 0; c < NUM_CELL; c++) begin : g_cell
    logic signed [ACC_W-1:0] tapSum;
    logic signed [ACC_W-1:0] feedBack;
    logic signed [ACC_W-1:0] accReg;
    logic signed [ACC_W-1:0] holdReg;

    always_comb begin
      tapSum = '0;
      for (int t = 0; t < NUM_MULT; t++) begin
        logic [PROD_W-1:0] p;
        p = prodBus[c][t*PROD_W +: PROD_W];
        tapSum = tapSum + {{EXT_W{p[PROD_W-1]}}, p};
      end
      feedBack = strobe.clearFb ? '0 : accReg;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        accReg  <= '0;
        holdReg <= '0;
      end else begin
        accReg <= feedBack + tapSum;
        if (strobe.loadHold) holdReg <= accReg;
      end
    end

    assign accOut[c]  = accReg;
    assign holdOut[c] = holdReg;
  end
endmodule

// File: rtl/dac_combiner.sv
module dac_combiner
  import dac_pkg::*;
#(
  parameter int ACC_W   = 28,
  parameter int B_SHIFT = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              modeSel,
  input  logic signed [ACC_W-1:0] holdA,
  input  logic signed [ACC_W-1:0] holdB,
  output logic [ACC_W-1:0]        dataOut
);
  logic signed [ACC_W-1:0] scaledB;
  logic signed [ACC_W-1:0] combined;

  always_comb begin
    scaledB = holdB >>> B_SHIFT;
    unique case (combMode_e'(modeSel))
      MODE_SCALED: combined = holdA + scaledB;
      MODE_SUM:    combined = holdA + holdB;
      MODE_A:      combined = holdA;
      MODE_B:      combined = holdB;
      default:     combined = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) dataOut <= '0;
    else     dataOut <= combined;
  end
endmodule

// File: rtl/dual_accum_combiner.sv
module dual_accum_combiner
  import dac_pkg::*;
#(
  parameter int PROD_W   = 20,
  parameter int NUM_MULT = 4,
  parameter int ACC_W    = 28,
  parameter int B_SHIFT  = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       accEn,
  input  logic [NUM_MULT*PROD_W-1:0] prodA,
  input  logic [NUM_MULT*PROD_W-1:0] prodB,
  input  logic [1:0]                 modeSel,
  output logic [ACC_W-1:0]           dataOut
);
  localparam int NUM_CELL = 2;

  dacStrobe_t                 strobe;
  logic [NUM_MULT*PROD_W-1:0] prodBus [NUM_CELL];
  logic signed [ACC_W-1:0]    accVal  [NUM_CELL];
  logic signed [ACC_W-1:0]    holdVal [NUM_CELL];

  assign prodBus[0] = prodA;
  assign prodBus[1] = prodB;

  dac_ctrl u_ctrl (
    .accEn  (accEn),
    .strobe (strobe)
  );

  dac_datapath #(
    .PROD_W   (PROD_W),
    .NUM_MULT (NUM_MULT),
    .ACC_W    (ACC_W),
    .NUM_CELL (NUM_CELL)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .prodBus (prodBus),
    .accOut  (accVal),
    .holdOut (holdVal)
  );

  dac_combiner #(
    .ACC_W   (ACC_W),
    .B_SHIFT (B_SHIFT)
  ) u_comb (
    .clk     (clk),
    .rst     (rst),
    .modeSel (modeSel),
    .holdA   (holdVal[0]),
    .holdB   (holdVal[1]),
    .dataOut (dataOut)
  );
endmodule

// File: rtl/dac_checker.sv
module dac_checker #(
  parameter int PROD_W   = 20,
  parameter int NUM_MULT = 4,
  parameter int ACC_W    = 28,
  parameter int B_SHIFT  = 10
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       accEn,
  input logic [NUM_MULT*PROD_W-1:0] prodA,
  input logic [NUM_MULT*PROD_W-1:0] prodB,
  input logic [1:0]                 modeSel,
  input logic signed [ACC_W-1:0]    accA,
  input logic signed [ACC_W-1:0]    accB,
  input logic signed [ACC_W-1:0]    holdA,
  input logic signed [ACC_W-1:0]    holdB,
  input logic [ACC_W-1:0]           dataOut
);
  function automatic logic signed [ACC_W-1:0] busSum(input logic [NUM_MULT*PROD_W-1:0] bus);
    logic signed [ACC_W-1:0] s;
    s = '0;
    for (int i = 0; i < NUM_MULT; i++)
      s = s + ACC_W'($signed(bus[i*PROD_W +: PROD_W]));
    return s;
  endfunction

  logic signed [ACC_W-1:0] sumA, sumB, expOut;
  always_comb begin
    sumA = busSum(prodA);
    sumB = busSum(prodB);
    case (modeSel)
      2'b00:   expOut = holdA + (holdB >>> B_SHIFT);
      2'b01:   expOut = holdA + holdB;
      2'b10:   expOut = holdA;
      default: expOut = holdB;
    endcase
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (dataOut == '0 && accA == '0 && accB == '0 && holdA == '0 && holdB == '0));

  assert_restart_sum_R2: assert property (@(posedge clk) disable iff (rst)
    !accEn |=> (accA == $past(sumA) && accB == $past(sumB)));

  assert_hold_load_R3: assert property (@(posedge clk) disable iff (rst)
    !accEn |=> (holdA == $past(accA) && holdB == $past(accB)));

  assert_hold_keep_R4: assert property (@(posedge clk) disable iff (rst)
    accEn |=> ($stable(holdA) && $stable(holdB)));

  assert_accumulate_R4: assert property (@(posedge clk) disable iff (rst)
    accEn |=> (accA == $past(accA + sumA) && accB == $past(accB + sumB)));

  assert_output_mode_R8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (dataOut == $past(expOut)));
endmodule

bind dual_accum_combiner dac_checker #(
  .PROD_W   (PROD_W),
  .NUM_MULT (NUM_MULT),
  .ACC_W    (ACC_W),
  .B_SHIFT  (B_SHIFT)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .accEn   (accEn),
  .prodA   (prodA),
  .prodB   (prodB),
  .modeSel (modeSel),
  .accA    (accVal[0]),
  .accB    (accVal[1]),
  .holdA   (holdVal[0]),
  .holdB   (holdVal[1]),
  .dataOut (dataOut)
);

// File: tb/sim_dual_accum_combiner.sv
`timescale 1ns/1ps
module sim_dual_accum_combiner;
  localparam int PW = 20;
  localparam int NM = 4;
  localparam int AW = 28;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          accEn = 1'b0;
  logic [NM*PW-1:0] prodA = '0, prodB = '0;
  logic [1:0]    modeSel = 2'b10;
  logic [AW-1:0] dataOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_accum_combiner u0 (
    .clk(clk), .rst(rst), .accEn(accEn), .prodA(prodA), .prodB(prodB),
    .modeSel(modeSel), .dataOut(dataOut)
  );

  // Behavioural reference model
  longint mAcc[2], mHold[2], mOut;
  logic [1:0] lastMode = 2'b10;

  function automatic longint wrap(input longint v);
    longint m;
    m = v & ((64'sd1 <<< AW) - 1);
    if (m[AW-1]) m = m - (64'sd1 <<< AW);
    return m;
  endfunction

  function automatic longint busTotal(input logic [NM*PW-1:0] bus);
    longint s;
    s = 0;
    for (int i = 0; i < NM; i++) s += longint'($signed(bus[i*PW +: PW]));
    return s;
  endfunction

  always @(posedge clk) begin
    longint nOut, sA, sB;
    if (rst) begin
      mAcc[0] = 0; mAcc[1] = 0; mHold[0] = 0; mHold[1] = 0; mOut = 0;
    end else begin
      case (modeSel)
        2'b00:   nOut = wrap(mHold[0] + (mHold[1] >>> 10));
        2'b01:   nOut = wrap(mHold[0] + mHold[1]);
        2'b10:   nOut = mHold[0];
        default: nOut = mHold[1];
      endcase
      sA = busTotal(prodA);
      sB = busTotal(prodB);
      if (!accEn) begin
        mHold[0] = mAcc[0]; mHold[1] = mAcc[1];
        mAcc[0] = wrap(sA); mAcc[1] = wrap(sB);
      end else begin
        mAcc[0] = wrap(mAcc[0] + sA); mAcc[1] = wrap(mAcc[1] + sB);
      end
      mOut = nOut;
    end
    lastMode <= modeSel;
  end

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      case (lastMode)
        2'b00:   check("R5 R2 R3 R4 R8 R9", dataOut, mOut[AW-1:0]);
        2'b01:   check("R6 R2 R3 R4 R8 R9", dataOut, mOut[AW-1:0]);
        default: check("R7 R2 R3 R4 R8 R9", dataOut, mOut[AW-1:0]);
      endcase
    end
  end

  task automatic step(input logic en, input logic [NM*PW-1:0] a,
                      input logic [NM*PW-1:0] b, input logic [1:0] m);
    @(negedge clk);
    #1;
    accEn = en; prodA = a; prodB = b; modeSel = m;
  endtask

  function automatic logic [NM*PW-1:0] rndBus();
    logic [NM*PW-1:0] v;
    for (int i = 0; i < NM; i++) v[i*PW +: PW] = PW'($urandom);
    return v;
  endfunction

  function automatic logic [NM*PW-1:0] fillBus(input logic [PW-1:0] p);
    logic [NM*PW-1:0] v;
    for (int i = 0; i < NM; i++) v[i*PW +: PW] = p;
    return v;
  endfunction

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [AW-1:0] frozen;
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rst = 1'b0;
    @(negedge clk);
    check("R1", dataOut, '0);

    // R5: small negative B is floored (-1 >>> 10 == -1)
    step(1'b0, '0, {{(NM-1)*PW{1'b0}}, {PW{1'b1}}}, 2'b00);
    step(1'b0, '0, '0, 2'b00);
    step(1'b0, '0, '0, 2'b00);
    @(negedge clk);
    check("R5", dataOut, {AW{1'b1}});

    // Random blocks of varying accumulation length over all modes
    for (int blk = 0; blk < 200; blk++) begin
      int len = 1 + ($urandom % 9);
      logic [1:0] m = 2'($urandom);
      for (int k = 0; k < len; k++) step(1'b1, rndBus(), rndBus(), m);
      step(1'b0, rndBus(), rndBus(), m);
    end

    // R4: holds and output frozen during a long enabled run (mode A)
    step(1'b0, fillBus(20'h7FFFF), fillBus(20'h80000), 2'b10);
    step(1'b1, fillBus(20'h7FFFF), fillBus(20'h80000), 2'b10);
    @(negedge clk);
    frozen = dataOut;
    // R9: full-scale products for 100 cycles wrap the 28-bit accumulators
    for (int k = 0; k < 100; k++) step(1'b1, fillBus(20'h7FFFF), fillBus(20'h80000), 2'b10);
    @(negedge clk);
    check("R4", dataOut, frozen);
    for (int m = 0; m < 4; m++) begin
      step(1'b0, '0, '0, 2'(m));
      step(1'b1, '0, '0, 2'(m));
    end

    // R1: reset in mid-run clears everything
    step(1'b1, rndBus(), rndBus(), 2'b01);
    @(negedge clk); #1; rst = 1'b1;
    @(negedge clk); #1; rst = 1'b0; accEn = 1'b0;
    @(negedge clk);
    check("R1", dataOut, '0);
    repeat (3) step(1'b0, '0, '0, 2'b01);
    @(negedge clk);
    check("R1", dataOut, '0);
    finishRun();
  end
endmodule